// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is the transmit half of a serial port, sized for the controlling node of a single-wire vehicle-style bus. Software, or a sequencer, writes bytes into a one-entry holding register. The block moves each byte into a shift register and sends it as a standard asynchronous frame, one bit per pulse on the `baud_tick` input. A separate baud generator supplies that pulse.

To start a message header, the controller first raises `brk_set`. This arms a break request, shown on `brk_pend`. The next byte that moves into the shift register then goes out as a long run of zeros instead of its data. The request clears itself in hardware once that frame's stop bit ends. Because of this, the byte written behind it, normally the 0x55 sync value, follows directly as an ordinary frame.

Top module: `uart_brk_tx`

## Requirements
- R1: A normal frame is a low start bit, then the eight data bits least-significant first, then a high stop bit. Each bit lasts from one `baud_tick` to the next.
- R2: `tx` is high whenever `tx_en` is low.
- R3: A break frame is a low start bit, then twelve low bits, then a high stop bit. The byte whose transfer started the break is discarded.
- R4: The break request is sampled when a byte moves from the holding register into the shift register. Raising `brk_set` after that move does not alter the frame already in progress. It turns the next transferred byte into a break.
- R5: `brk_pend` stays high for the whole break frame. It falls in the same cycle that `shift_empty` rises at the end of that frame's stop bit, and not at any other time.
- R6: A byte written while a break is in progress is sent as a normal frame immediately after the break.
- R7: `buf_empty` is high when the holding register can accept a byte. An accepted write drives it low from the next cycle until the byte moves to the shift register.
- R8: A write while `buf_empty` is low is ignored: no extra frame is ever sent for it.
- R9: `shift_empty` is low while any frame, normal or break, is being sent. It is high when the transmitter is idle, and `tx` is then high.
- R10: Lowering `tx_en` during a frame aborts that frame in the next cycle. `shift_empty` returns high and `tx` stays high. A byte in the holding register waits until `tx_en` returns.
- R11: After reset, `tx`, `buf_empty` and `shift_empty` are high and `brk_pend` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable |
| brk_set | input | 1 | Pulse that arms a break for the next transferred byte |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to write |
| tx | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame is in progress |
| brk_pend | output | 1 | Break request armed and not yet completed |

## Verification
A bit counter that sits in the wrong state shows up at the port as a frame of the wrong length. The error appears at the first baud tick after the stop bit should have been sent, and the scoreboard then sees either a missing stop bit or an unexpected extra bit. If the break request is sampled at the wrong moment, it changes which frame carries twelve zeros; this becomes visible within one frame time. If the holding flag goes wrong, it shows as a lost or duplicated byte, or as `buf_empty` failing to drop in the cycle after a write.

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_set,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              brk_pend
);
  localparam int NORM_LAST = DATA_W + 1;
  localparam int BRK_LAST  = BRK_BITS + 1;
  localparam int MAX_LAST  = (NORM_LAST > BRK_LAST) ? NORM_LAST : BRK_LAST;
  localparam int CNT_W     = $clog2(MAX_LAST + 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic              busy;
  logic              brk_frame;
  logic [CNT_W-1:0]  bit_idx;

  logic [CNT_W-1:0] last_idx;
  logic             at_stop;
  logic             load;
  logic             end_frame;
  logic             bit_val;

  assign last_idx  = brk_frame ? CNT_W'(BRK_LAST) : CNT_W'(NORM_LAST);
  assign at_stop   = (bit_idx == last_idx);
  assign load      = hold_full & ~busy & tx_en;
  assign end_frame = busy & tx_en & baud_tick & at_stop;
  assign bit_val   = (bit_idx == '0) ? 1'b0 : (at_stop ? 1'b1 : sh_q[0]);

  assign tx          = ~(busy & tx_en) | bit_val;
  assign buf_empty   = ~hold_full;
  assign shift_empty = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (wr_stb && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      brk_frame <= 1'b0;
      bit_idx   <= '0;
      sh_q      <= '0;
    end else if (!tx_en) begin
      busy <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      brk_frame <= brk_pend;
      bit_idx   <= '0;
      sh_q      <= brk_pend ? '0 : hold_q;
    end else if (busy && baud_tick) begin
      if (at_stop) begin
        busy <= 1'b0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx != '0) sh_q <= sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      brk_pend <= 1'b0;
    else if (brk_set)                brk_pend <= 1'b1;
    else if (end_frame && brk_frame) brk_pend <= 1'b0;
  end
endmodule

// File: rtl/uart_brk_tx_sva.sv
module uart_brk_tx_sva (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic tx,
  input logic buf_empty,
  input logic shift_empty,
  input logic brk_pend
);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !tx);
  a_r2_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx);
  a_r5_brk_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_pend) |-> $rose(shift_empty));
  a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && wr_stb) |=> !buf_empty);
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !shift_empty) |=> shift_empty);
endmodule

bind uart_brk_tx uart_brk_tx_sva u_sva (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .tx(tx),
  .buf_empty(buf_empty), .shift_empty(shift_empty), .brk_pend(brk_pend)
);

// File: tb/uart_brk_tx_bench.sv
module uart_brk_tx_bench;
  localparam int DIV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b0;
  logic brk_set = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic tx, buf_empty, shift_empty, brk_pend;

  int checks = 0;
  int fails = 0;
  bit skip = 1'b0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  uart_brk_tx u_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_set(brk_set), .wr_stb(wr_stb), .wr_data(wr_data), .tx(tx),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .brk_pend(brk_pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      for (int i = 0; i < DIV - 1; i++) @(posedge clk);
      #1 baud_tick = 1'b1;
      @(posedge clk);
      #1 baud_tick = 1'b0;
    end
  end

  // R1 R3 R6 scoreboard: each line bit sampled on its closing tick
  initial begin
    forever begin
      @(negedge clk);
      if (baud_tick && !shift_empty && !skip) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected bit", int'(tx), -1);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(tx == e, "R1/R3 line bit", int'(tx), int'(e));
        end
      end
    end
  end

  task automatic push_frame(input logic [7:0] d, input bit brk);
    exp_q.push_back(1'b0);
    if (brk) for (int i = 0; i < 12; i++) exp_q.push_back(1'b0);
    else     for (int i = 0; i < 8; i++)  exp_q.push_back(d[i]);
    exp_q.push_back(1'b1);
  endtask

  task automatic wr(input logic [7:0] d, input bit brk, input bit expect_it);
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
    if (expect_it) push_frame(d, brk);
    @(posedge clk) #1;
    wr_stb = 1'b1; wr_data = d;
    @(posedge clk) #1;
    wr_stb = 1'b0;
  endtask

  task automatic pulse_brk();
    @(posedge clk) #1 brk_set = 1'b1;
    @(posedge clk) #1 brk_set = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || !shift_empty || !buf_empty) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(tx == 1'b1, "R11 tx", int'(tx), 1);
    chk(buf_empty == 1'b1, "R11 buf_empty", int'(buf_empty), 1);
    chk(shift_empty == 1'b1, "R11 shift_empty", int'(shift_empty), 1);
    chk(brk_pend == 1'b0, "R11 brk_pend", int'(brk_pend), 0);
    @(posedge clk) #1 rst_n = 1'b1; tx_en = 1'b1;

    // R1 normal frames, R7 buffer flag after a write to an idle transmitter
    wr(8'hA5, 1'b0, 1'b1);
    @(negedge clk);
    chk(buf_empty == 1'b0, "R7 buf_empty low after write", int'(buf_empty), 0);
    wr(8'h3C, 1'b0, 1'b1);
    wr(8'h01, 1'b0, 1'b1);
    wait_idle();
    chk(tx == 1'b1, "R9 idle line high", int'(tx), 1);

    // R8 write while holding register full
    wr(8'h80, 1'b0, 1'b1);
    wr(8'h7E, 1'b0, 1'b1);
    @(negedge clk);
    chk(buf_empty == 1'b0, "R8 buffer full", int'(buf_empty), 0);
    @(posedge clk) #1 wr_stb = 1'b1; wr_data = 8'hFF;
    @(posedge clk) #1 wr_stb = 1'b0;
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    chk(shift_empty == 1'b1, "R8 no extra frame", int'(shift_empty), 1);

    // R3 R5 R6 break, then sync queued behind it
    pulse_brk();
    @(negedge clk);
    chk(brk_pend == 1'b1, "R5 brk_pend armed", int'(brk_pend), 1);
    wr(8'hFF, 1'b1, 1'b1);
    wr(8'h55, 1'b0, 1'b1);
    @(negedge clk);
    chk(shift_empty == 1'b0, "R9 busy during break", int'(shift_empty), 0);
    chk(brk_pend == 1'b1, "R5 brk_pend held during break", int'(brk_pend), 1);
    wait_idle();
    chk(brk_pend == 1'b0, "R5 brk_pend cleared", int'(brk_pend), 0);

    // R4 request raised after transfer affects the next byte only
    wr(8'hC3, 1'b0, 1'b1);
    @(negedge clk);
    while (shift_empty) @(negedge clk);
    pulse_brk();
    wr(8'hAA, 1'b1, 1'b1);
    wait_idle();
    chk(brk_pend == 1'b0, "R4 brk_pend cleared after second frame", int'(brk_pend), 0);

    // R10 abort mid-frame, R2 held byte waits while disabled
    skip = 1'b1;
    wr(8'h0F, 1'b0, 1'b0);
    repeat (3 * DIV) @(negedge clk);
    @(posedge clk) #1 tx_en = 1'b0;
    @(negedge clk);
    chk(tx == 1'b1, "R2 line high once disabled", int'(tx), 1);
    @(negedge clk);
    chk(shift_empty == 1'b1, "R10 frame aborted", int'(shift_empty), 1);
    chk(tx == 1'b1, "R10 line high after abort", int'(tx), 1);
    @(posedge clk) #1 wr_stb = 1'b1; wr_data = 8'h96;
    @(posedge clk) #1 wr_stb = 1'b0;
    for (int k = 0; k < 3; k++) begin
      repeat (DIV) @(negedge clk);
      chk(tx == 1'b1 && shift_empty == 1'b1, "R2 held while disabled", int'(tx), 1);
    end
    chk(buf_empty == 1'b0, "R10 byte waits", int'(buf_empty), 0);
    skip = 1'b0;
    push_frame(8'h96, 1'b0);
    @(posedge clk) #1 tx_en = 1'b1;
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule